// File: doc/BRIEF.md
# Region Access Permission Checker

This block sits beside the bus fabric and checks every access on a small set of access paths against a table of address regions. Each bus master belongs to a security mode held in a per-master mode table. Mode 0 is the trusted mode. Modes 1 to 3 are less-trusted execution environments. For an access from a less-trusted master, the block looks for the lowest-numbered enabled region that contains the address. It then tests the read, write or execute bit that the region grants to that master's mode. An access that fails this test is refused.

A refused access raises an error indication on its path in the same cycle. On the next clock edge, the first refusal on a path is stored in a per-path exception record. That record holds the master, the access kind, the mode, the region and the full address. It stays frozen until software clears it. Each path can raise an interrupt while its record is valid. All tables and enables are programmed through a simple word-addressed write port with a combinational read-back.

Top module: `acc_guard`

## Requirements
- R1: After reset, every master is in mode 0, every enable register (region, path, interrupt) reads 0, every exception status reads 0, and no access is refused.
- R2: An access from a master whose mode is 0 is never refused.
- R3: An access path whose bit in the path-enable register (offset 0x204, bit p) is 0 never refuses an access.
- R4: A region r takes part in matching only while bit r of the region-enable register (offset 0x200) is 1. It matches when start <= address <= end, both bounds inclusive. When several regions match, the lowest index is used.
- R5: For mode m (1 to 3), the permission field is bits [4m-1:4m-4] of the region's attribute word. Within the field, bit 2 grants read, bit 1 grants write and bit 0 grants execute. Access kind 0 is a read, 1 is a write and 2 is an execute. Kind 3 is always refused for modes 1 to 3.
- R6: An access from a less-trusted master that matches no enabled region is refused.
- R7: acc_deny_o[p] is combinational in the cycle the access is presented, and is 0 while acc_valid_i[p] is 0.
- R8: On the clock edge after the first refusal on path p, the status of path p becomes 1 and its record is stored. The info word holds master ID in [4:0], access kind in [9:8], mode in [13:12], region in [19:16] (0 on no match) and a no-match flag in [24]. The address word holds the full faulting address.
- R9: While the status of a path is 1, later refusals on that path do not change its status, info word or address word.
- R10: Writing a word with bit 0 set to a path's clear register clears that path's status on the next edge; bit 0 clear has no effect. A clear wins over a refusal in the same cycle, which is then not recorded.
- R11: irq_o[p] is 1 exactly while path p's status is 1 and bit p of the interrupt-enable register (offset 0x208) is 1.
- R12: Register map. The mode of master i is at 0x000+4i, in bits [1:0]. Region r has its start at 0x100+12r, its end at +4 and its attribute word (12 bits) at +8. Path p has status at 0x300+16p (bit 0), clear at +4 (reads 0), info at +8 and address at +12. Every writable register reads back its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration byte address |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Combinational read data at cfg_addr_i |
| acc_valid_i | input | NUM_PATHS | Access present on each path |
| acc_addr_i | input | NUM_PATHS*ADDR_W | Access address per path |
| acc_mid_i | input | NUM_PATHS*MID_W | Master ID per path |
| acc_kind_i | input | NUM_PATHS*2 | Access kind per path: 0 read, 1 write, 2 execute |
| acc_deny_o | output | NUM_PATHS | Access refused, same cycle |
| irq_o | output | NUM_PATHS | Per-path exception interrupt |

## Verification
A wrong mode entry, bound or attribute bit shows up at acc_deny_o in the same cycle as the access. The bench therefore sweeps every mode, every access kind and addresses on and around each region boundary, with overlapping and disabled regions in the table. A wrong capture or freeze condition shows up one edge later, as the wrong first refusal in a path's read-back record. A wrong clear or interrupt gating shows up on irq_o at the next edge.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;
  typedef enum logic [1:0] {
    KIND_RD  = 2'd0,
    KIND_WR  = 2'd1,
    KIND_EX  = 2'd2,
    KIND_RSV = 2'd3
  } acc_kind_e;

  localparam int unsigned OFS_MODE    = 32'h000;
  localparam int unsigned OFS_RGN     = 32'h100;
  localparam int unsigned RGN_STRIDE  = 12;
  localparam int unsigned OFS_RGN_EN  = 32'h200;
  localparam int unsigned OFS_PATH_EN = 32'h204;
  localparam int unsigned OFS_IRQ_EN  = 32'h208;
  localparam int unsigned OFS_EXC     = 32'h300;
  localparam int unsigned EXC_STRIDE  = 16;

  localparam int FIELD_W  = 4;
  localparam int PERM_W   = 3;
  localparam int LT_MODES = 3;
  localparam int ATTR_W   = FIELD_W * LT_MODES;
  localparam int RPERM_W  = PERM_W * LT_MODES;
endpackage

// File: rtl/acc_guard_cfg.sv
module acc_guard_cfg
  import acc_guard_pkg::*;
#(
  parameter int NM  = 32,
  parameter int NR  = 16,
  parameter int NP  = 4,
  parameter int AW  = 32,
  parameter int CAW = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CAW-1:0]    addr_i,
  input  logic [31:0]       wdata_i,
  output logic [NM*2-1:0]   mode_tbl_o,
  output logic [NR*AW-1:0]  rgn_start_o,
  output logic [NR*AW-1:0]  rgn_end_o,
  output logic [NR*RPERM_W-1:0] rgn_perm_o,
  output logic [NR-1:0]     rgn_en_o,
  output logic [NP-1:0]     path_en_o,
  output logic [NP-1:0]     irq_en_o,
  output logic [NP-1:0]     clr_o,
  output logic [31:0]       rdata_o
);
  logic [NR*ATTR_W-1:0] rgn_attr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_tbl_o  <= '0;
      rgn_start_o <= '0;
      rgn_end_o   <= '0;
      rgn_attr_q  <= '0;
      rgn_en_o    <= '0;
      path_en_o   <= '0;
      irq_en_o    <= '0;
    end else if (we_i) begin
      for (int m = 0; m < NM; m++)
        if (addr_i == CAW'(OFS_MODE + 4*m)) mode_tbl_o[2*m +: 2] <= wdata_i[1:0];
      for (int r = 0; r < NR; r++) begin
        if (addr_i == CAW'(OFS_RGN + RGN_STRIDE*r))     rgn_start_o[r*AW +: AW]   <= wdata_i[AW-1:0];
        if (addr_i == CAW'(OFS_RGN + RGN_STRIDE*r + 4)) rgn_end_o[r*AW +: AW]     <= wdata_i[AW-1:0];
        if (addr_i == CAW'(OFS_RGN + RGN_STRIDE*r + 8)) rgn_attr_q[r*ATTR_W +: ATTR_W] <= wdata_i[ATTR_W-1:0];
      end
      if (addr_i == CAW'(OFS_RGN_EN))  rgn_en_o  <= wdata_i[NR-1:0];
      if (addr_i == CAW'(OFS_PATH_EN)) path_en_o <= wdata_i[NP-1:0];
      if (addr_i == CAW'(OFS_IRQ_EN))  irq_en_o  <= wdata_i[NP-1:0];
    end
  end

  // Permission bits only; the spare top bit of each field is storage for read-back.
  for (genvar r = 0; r < NR; r++) begin : g_perm
    for (genvar m = 0; m < LT_MODES; m++) begin : g_mode
      assign rgn_perm_o[r*RPERM_W + m*PERM_W +: PERM_W] =
        rgn_attr_q[r*ATTR_W + m*FIELD_W +: PERM_W];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_clr
    assign clr_o[p] = we_i && wdata_i[0] &&
                      (addr_i == CAW'(OFS_EXC + EXC_STRIDE*p + 4));
  end

  always_comb begin
    rdata_o = '0;
    for (int m = 0; m < NM; m++)
      if (addr_i == CAW'(OFS_MODE + 4*m)) rdata_o = 32'(mode_tbl_o[2*m +: 2]);
    for (int r = 0; r < NR; r++) begin
      if (addr_i == CAW'(OFS_RGN + RGN_STRIDE*r))     rdata_o = 32'(rgn_start_o[r*AW +: AW]);
      if (addr_i == CAW'(OFS_RGN + RGN_STRIDE*r + 4)) rdata_o = 32'(rgn_end_o[r*AW +: AW]);
      if (addr_i == CAW'(OFS_RGN + RGN_STRIDE*r + 8)) rdata_o = 32'(rgn_attr_q[r*ATTR_W +: ATTR_W]);
    end
    if (addr_i == CAW'(OFS_RGN_EN))  rdata_o = 32'(rgn_en_o);
    if (addr_i == CAW'(OFS_PATH_EN)) rdata_o = 32'(path_en_o);
    if (addr_i == CAW'(OFS_IRQ_EN))  rdata_o = 32'(irq_en_o);
  end
endmodule

// File: rtl/acc_guard_path.sv
module acc_guard_path
  import acc_guard_pkg::*;
#(
  parameter int NM    = 32,
  parameter int NR    = 16,
  parameter int AW    = 32,
  parameter int MID_W = 5,
  parameter int RGN_W = 4
) (
  input  logic               valid_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [MID_W-1:0]   mid_i,
  input  logic [1:0]         kind_i,
  input  logic               path_en_i,
  input  logic [NM*2-1:0]    mode_tbl_i,
  input  logic [NR*AW-1:0]   rgn_start_i,
  input  logic [NR*AW-1:0]   rgn_end_i,
  input  logic [NR*RPERM_W-1:0] rgn_perm_i,
  input  logic [NR-1:0]      rgn_en_i,
  output logic               deny_o,
  output logic               trusted_o,
  output logic [1:0]         mode_o,
  output logic               hit_o,
  output logic [RGN_W-1:0]   rgn_o
);
  logic [PERM_W-1:0] perm;
  logic              perm_ok;

  assign mode_o    = mode_tbl_i[int'(mid_i)*2 +: 2];
  assign trusted_o = (mode_o == 2'd0);

  // Descending scan: the last hit assigned is the lowest index.
  always_comb begin
    hit_o = 1'b0;
    rgn_o = '0;
    for (int r = NR-1; r >= 0; r--) begin
      if (rgn_en_i[r] &&
          addr_i >= rgn_start_i[r*AW +: AW] &&
          addr_i <= rgn_end_i[r*AW +: AW]) begin
        hit_o = 1'b1;
        rgn_o = RGN_W'(r);
      end
    end
  end

  always_comb begin
    case (mode_o)
      2'd1:    perm = rgn_perm_i[int'(rgn_o)*RPERM_W          +: PERM_W];
      2'd2:    perm = rgn_perm_i[int'(rgn_o)*RPERM_W + PERM_W   +: PERM_W];
      2'd3:    perm = rgn_perm_i[int'(rgn_o)*RPERM_W + 2*PERM_W +: PERM_W];
      default: perm = '0;
    endcase
    case (acc_kind_e'(kind_i))
      KIND_RD: perm_ok = perm[2];
      KIND_WR: perm_ok = perm[1];
      KIND_EX: perm_ok = perm[0];
      default: perm_ok = 1'b0;
    endcase
  end

  assign deny_o = valid_i && path_en_i && !trusted_o && (!hit_o || !perm_ok);
endmodule

// File: rtl/acc_guard_exc.sv
module acc_guard_exc #(
  parameter int AW    = 32,
  parameter int MID_W = 5,
  parameter int RGN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             clr_i,
  input  logic [MID_W-1:0] mid_i,
  input  logic [1:0]       kind_i,
  input  logic [1:0]       mode_i,
  input  logic             nomatch_i,
  input  logic [RGN_W-1:0] rgn_i,
  input  logic [AW-1:0]    addr_i,
  output logic             status_o,
  output logic [31:0]      info_o,
  output logic [AW-1:0]    addr_o
);
  logic [31:0] info_d;

  assign info_d = 32'(mid_i) | (32'(kind_i) << 8) | (32'(mode_i) << 12) |
                  (32'(rgn_i) << 16) | (32'(nomatch_i) << 24);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= 1'b0;
      info_o   <= '0;
      addr_o   <= '0;
    end else if (clr_i) begin
      status_o <= 1'b0;
    end else if (evt_i && !status_o) begin
      status_o <= 1'b1;
      info_o   <= info_d;
      addr_o   <= addr_i;
    end
  end
endmodule

// File: rtl/acc_guard.sv
module acc_guard
  import acc_guard_pkg::*;
#(
  parameter int NUM_MASTERS = 32,
  parameter int NUM_REGIONS = 16,
  parameter int NUM_PATHS   = 4,
  parameter int ADDR_W      = 32,
  parameter int CFG_AW      = 12,
  localparam int MID_W      = $clog2(NUM_MASTERS),
  localparam int RGN_W      = $clog2(NUM_REGIONS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cfg_we_i,
  input  logic [CFG_AW-1:0]           cfg_addr_i,
  input  logic [31:0]                 cfg_wdata_i,
  output logic [31:0]                 cfg_rdata_o,
  input  logic [NUM_PATHS-1:0]        acc_valid_i,
  input  logic [NUM_PATHS*ADDR_W-1:0] acc_addr_i,
  input  logic [NUM_PATHS*MID_W-1:0]  acc_mid_i,
  input  logic [NUM_PATHS*2-1:0]      acc_kind_i,
  output logic [NUM_PATHS-1:0]        acc_deny_o,
  output logic [NUM_PATHS-1:0]        irq_o
);
  logic [NUM_MASTERS*2-1:0]          mode_tbl;
  logic [NUM_REGIONS*ADDR_W-1:0]     rgn_start, rgn_end;
  logic [NUM_REGIONS*RPERM_W-1:0]    rgn_perm;
  logic [NUM_REGIONS-1:0]            rgn_en;
  logic [NUM_PATHS-1:0]              path_en, irq_en, exc_clr, exc_status, path_trusted;
  logic [NUM_PATHS*32-1:0]           exc_info;
  logic [NUM_PATHS*ADDR_W-1:0]       exc_addr;
  logic [31:0]                       cfg_rd, exc_rd;

  acc_guard_cfg #(
    .NM(NUM_MASTERS), .NR(NUM_REGIONS), .NP(NUM_PATHS), .AW(ADDR_W), .CAW(CFG_AW)
  ) cfg_i (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .mode_tbl_o(mode_tbl), .rgn_start_o(rgn_start), .rgn_end_o(rgn_end),
    .rgn_perm_o(rgn_perm), .rgn_en_o(rgn_en), .path_en_o(path_en),
    .irq_en_o(irq_en), .clr_o(exc_clr), .rdata_o(cfg_rd)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    logic             hit;
    logic [RGN_W-1:0] rgn;
    logic [1:0]       mode;

    acc_guard_path #(
      .NM(NUM_MASTERS), .NR(NUM_REGIONS), .AW(ADDR_W), .MID_W(MID_W), .RGN_W(RGN_W)
    ) chk_i (
      .valid_i(acc_valid_i[p]),
      .addr_i(acc_addr_i[p*ADDR_W +: ADDR_W]),
      .mid_i(acc_mid_i[p*MID_W +: MID_W]),
      .kind_i(acc_kind_i[p*2 +: 2]),
      .path_en_i(path_en[p]),
      .mode_tbl_i(mode_tbl), .rgn_start_i(rgn_start), .rgn_end_i(rgn_end),
      .rgn_perm_i(rgn_perm), .rgn_en_i(rgn_en),
      .deny_o(acc_deny_o[p]), .trusted_o(path_trusted[p]),
      .mode_o(mode), .hit_o(hit), .rgn_o(rgn)
    );

    acc_guard_exc #(.AW(ADDR_W), .MID_W(MID_W), .RGN_W(RGN_W)) exc_i (
      .clk_i, .rst_ni,
      .evt_i(acc_deny_o[p]), .clr_i(exc_clr[p]),
      .mid_i(acc_mid_i[p*MID_W +: MID_W]),
      .kind_i(acc_kind_i[p*2 +: 2]),
      .mode_i(mode), .nomatch_i(!hit), .rgn_i(rgn),
      .addr_i(acc_addr_i[p*ADDR_W +: ADDR_W]),
      .status_o(exc_status[p]),
      .info_o(exc_info[p*32 +: 32]),
      .addr_o(exc_addr[p*ADDR_W +: ADDR_W])
    );

    assign irq_o[p] = exc_status[p] & irq_en[p];
  end

  always_comb begin
    exc_rd = '0;
    for (int p = 0; p < NUM_PATHS; p++) begin
      if (cfg_addr_i == CFG_AW'(OFS_EXC + EXC_STRIDE*p))      exc_rd = 32'(exc_status[p]);
      if (cfg_addr_i == CFG_AW'(OFS_EXC + EXC_STRIDE*p + 8))  exc_rd = exc_info[p*32 +: 32];
      if (cfg_addr_i == CFG_AW'(OFS_EXC + EXC_STRIDE*p + 12)) exc_rd = 32'(exc_addr[p*ADDR_W +: ADDR_W]);
    end
  end

  assign cfg_rdata_o = cfg_rd | exc_rd;
endmodule

// File: rtl/acc_guard_chk.sv
module acc_guard_chk #(
  parameter int NP = 4,
  parameter int AW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NP-1:0]   valid_i,
  input logic [NP-1:0]   deny_i,
  input logic [NP-1:0]   trusted_i,
  input logic [NP-1:0]   path_en_i,
  input logic [NP-1:0]   status_i,
  input logic [NP-1:0]   clr_i,
  input logic [NP*32-1:0] info_i,
  input logic [NP*AW-1:0] addr_i
);
  for (genvar p = 0; p < NP; p++) begin : g_p
    AST_TRUSTED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trusted_i[p] |-> !deny_i[p]);                                            // R2
    AST_PATH_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !path_en_i[p] |-> !deny_i[p]);                                           // R3
    AST_IDLE_NO_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i[p] |-> !deny_i[p]);                                             // R7
    AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      deny_i[p] && !status_i[p] && !clr_i[p] |=> status_i[p]);                 // R8
    AST_RECORD_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_i[p] && !clr_i[p] |=> status_i[p] && $stable(info_i[p*32 +: 32])
                                   && $stable(addr_i[p*AW +: AW]));            // R9
    AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[p] |=> !status_i[p]);                                              // R10
  end
endmodule

bind acc_guard acc_guard_chk #(.NP(NUM_PATHS), .AW(ADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .valid_i(acc_valid_i), .deny_i(acc_deny_o), .trusted_i(path_trusted),
  .path_en_i(path_en), .status_i(exc_status), .clr_i(exc_clr),
  .info_i(exc_info), .addr_i(exc_addr)
);

// File: tb/acc_guard_tb_top.sv
`timescale 1ns/1ps
module acc_guard_tb_top;
  localparam int NP = 4;
  localparam int AW = 32;
  localparam int MW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [NP-1:0] valid = '0, deny, irq;
  logic [NP*AW-1:0] a_addr = '0;
  logic [NP*MW-1:0] a_mid = '0;
  logic [NP*2-1:0] a_kind = '0;

  int n_chk = 0, n_fail = 0;

  logic [1:0]  m_mode [32];
  logic [31:0] m_rs [16], m_re [16];
  logic [11:0] m_ra [16];
  logic [15:0] m_ren = '0;
  logic [3:0]  m_pen = '0;

  always #2.5 clk = ~clk;

  acc_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .acc_valid_i(valid),
    .acc_addr_i(a_addr), .acc_mid_i(a_mid), .acc_kind_i(a_kind),
    .acc_deny_o(deny), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    cfg_addr = a; #0.5; d = cfg_rdata;
  endtask

  task automatic set_mode(int mid, logic [1:0] md);
    wr(12'(4*mid), 32'(md)); m_mode[mid] = md;
  endtask

  task automatic set_rgn(int r, logic [31:0] s, logic [31:0] e, logic [11:0] at);
    wr(12'(12'h100 + 12*r), s); wr(12'(12'h100 + 12*r + 4), e);
    wr(12'(12'h100 + 12*r + 8), 32'(at));
    m_rs[r] = s; m_re[r] = e; m_ra[r] = at;
  endtask

  // Drive one access on path p at a falling edge; others idle.
  task automatic drive(int p, int mid, int kind, logic [31:0] a);
    @(negedge clk);
    valid = '0; valid[p] = 1'b1;
    a_addr[p*AW +: AW] = a; a_mid[p*MW +: MW] = 5'(mid); a_kind[p*2 +: 2] = 2'(kind);
    #0.5;
  endtask

  function automatic bit model(int p, int mid, int kind, logic [31:0] a,
                               output int rg, output bit nm, output int md);
    logic [3:0] f;
    md = int'(m_mode[mid]); rg = 0; nm = 1'b1;
    for (int r = 15; r >= 0; r--)
      if (m_ren[r] && a >= m_rs[r] && a <= m_re[r]) begin rg = r; nm = 1'b0; end
    if (!m_pen[p] || md == 0) return 1'b0;
    if (nm) return 1'b1;
    f = 4'(m_ra[rg] >> (4*(md-1)));
    case (kind)
      0: return !f[2];
      1: return !f[1];
      2: return !f[0];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] pack_info(int mid, int kind, int md, int rg, bit nm);
    return 32'(mid) | (32'(kind) << 8) | (32'(md) << 12) | (32'(rg) << 16) | (32'(nm) << 24);
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] addrs [12];
    int mids [4];
    bit seen [NP];
    logic [31:0] e_info [NP], e_addr [NP];
    int rg, md; bit nm, ex;

    for (int i = 0; i < 32; i++) m_mode[i] = 2'd0;
    for (int i = 0; i < 16; i++) begin m_rs[i] = '0; m_re[i] = '0; m_ra[i] = '0; end
    addrs = '{32'h0FFF, 32'h1000, 32'h17FF, 32'h1800, 32'h1FFF, 32'h2000,
              32'h2FFF, 32'h3000, 32'h4000, 32'h8000, 32'h8001, 32'hFFFF_FFFF};
    mids = '{0, 1, 2, 31};

    #12 rst_n = 1'b1;

    // R1 reset state
    rd(12'h204, d); check("R1 path_en", d, 0);
    rd(12'h200, d); check("R1 rgn_en", d, 0);
    rd(12'h208, d); check("R1 irq_en", d, 0);
    rd(12'h014, d); check("R1 mode of master 5", d, 0);
    rd(12'h310, d); check("R1 status path1", d, 0);
    drive(0, 7, 1, 32'h1234);
    check("R1 no deny after reset", 32'(deny), 0);
    @(negedge clk); valid = '0;

    // configuration
    set_mode(1, 2'd1); set_mode(2, 2'd2); set_mode(31, 2'd3);
    set_rgn(0, 32'h1000, 32'h1FFF, 12'h016);
    set_rgn(1, 32'h1800, 32'h2FFF, 12'h477);
    set_rgn(2, 32'h4000, 32'h4FFF, 12'h777);
    set_rgn(15, 32'h8000, 32'h8000, 12'h200);
    wr(12'h200, 32'h8003); m_ren = 16'h8003;
    wr(12'h204, 32'h7);    m_pen = 4'h7;

    // R12 read-back
    rd(12'h100 + 12'd16, d); check("R12 rgn1 end", d, 32'h2FFF);
    rd(12'h100 + 12'd20, d); check("R12 rgn1 attr", d, 32'h477);
    rd(12'h07C, d);          check("R12 mode of master 31", d, 3);
    rd(12'h314, d);          check("R12 clear reads 0", d, 0);

    // sweep: R2 R3 R4 R5 R6 R7
    for (int p = 0; p < NP; p++) seen[p] = 1'b0;
    for (int p = 0; p < NP; p++)
      for (int mi = 0; mi < 4; mi++)
        for (int k = 0; k < 4; k++)
          for (int ai = 0; ai < 12; ai++) begin
            drive(p, mids[mi], k, addrs[ai]);
            ex = model(p, mids[mi], k, addrs[ai], rg, nm, md);
            check($sformatf("R5 deny p%0d mid%0d k%0d a%h (R2 R3 R4 R6)", p, mids[mi], k, addrs[ai]),
                  32'(deny), 32'(ex) << p);
            if (ex && !seen[p]) begin
              seen[p] = 1'b1;
              e_info[p] = pack_info(mids[mi], k, md, rg, nm);
              e_addr[p] = addrs[ai];
            end
          end
    @(negedge clk); valid = '0;
    #0.5;
    check("R7 idle no deny", 32'(deny), 0);

    // R8 R9 first refusal held per path
    for (int p = 0; p < NP; p++) begin
      rd(12'(12'h300 + 16*p), d); check($sformatf("R8 status p%0d", p), d, 32'(seen[p]));
      if (seen[p]) begin
        rd(12'(12'h308 + 16*p), d); check($sformatf("R9 info p%0d", p), d, e_info[p]);
        rd(12'(12'h30C + 16*p), d); check($sformatf("R9 addr p%0d", p), d, e_addr[p]);
      end
    end

    // R11 gating
    check("R11 irq masked", 32'(irq), 0);
    wr(12'h208, 32'hF);
    #0.5; check("R11 irq follows status", 32'(irq), 32'h7);

    // R10 clear
    wr(12'h314, 32'h0);
    rd(12'h310, d); check("R10 clear bit0=0 ignored", d, 1);
    wr(12'h304, 32'h1);
    rd(12'h300, d); check("R10 status cleared", d, 0);
    check("R11 irq dropped", 32'(irq), 32'h6);

    // R8 fresh capture, R9 frozen against a later refusal
    drive(0, 31, 1, 32'h3000);
    drive(0, 1, 2, 32'h1000);
    @(negedge clk); valid = '0;
    rd(12'h308, d); check("R8 info nomatch", d, pack_info(31, 1, 3, 0, 1'b1));
    rd(12'h30C, d); check("R9 addr frozen", d, 32'h3000);
    check("R11 irq set again", 32'(irq), 32'h7);

    // R10 clear beats a same-cycle refusal
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 12'h304; cfg_wdata = 32'h1;
    valid = 4'b0001; a_addr[0 +: AW] = 32'h3000; a_mid[0 +: MW] = 5'd31; a_kind[0 +: 2] = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; valid = '0;
    rd(12'h300, d); check("R10 clear wins", d, 0);

    // R4 region enable at run time
    drive(1, 31, 0, 32'h4000);
    check("R4 disabled region refuses", 32'(deny), 32'h2);
    @(negedge clk); valid = '0;
    wr(12'h200, 32'h8007); m_ren = 16'h8007;
    drive(1, 31, 0, 32'h4000);
    check("R4 enabled region allows", 32'(deny), 0);
    drive(1, 31, 3, 32'h4000);
    check("R5 kind 3 refused", 32'(deny), 32'h2);
    @(negedge clk); valid = '0;

    // R2 mode change to trusted, R3 path disable
    set_mode(31, 2'd0);
    drive(2, 31, 1, 32'h3000);
    check("R2 trusted after mode change", 32'(deny), 0);
    @(negedge clk); valid = '0;
    set_mode(1, 2'd1);
    wr(12'h204, 32'h6); m_pen = 4'h6;
    drive(0, 1, 1, 32'h3000);
    check("R3 disabled path bypass", 32'(deny), 0);
    @(negedge clk); valid = '0;
    rd(12'h300, d); check("R3 no capture on bypass", d, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule